// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is a 32-word by 32-bit register file. In every clock cycle it serves two reads and one write. Each read port samples its address on the rising edge. It presents the addressed word on its output from that edge on and holds it until the next edge. The write port commits its data on the same edge, but only when the write enable is high and the target is not entry zero.

A read port whose address matches a write that commits in the same cycle returns the incoming data, not the old stored word. The two read ports apply this rule independently of each other. Entry zero is a hard-wired zero. Writes aimed at it are dropped, and they are not forwarded to either read port. All stored words and both read outputs start at zero at power-up. The file has no reset input.

The block is meant to sit in a processor pipeline. There it supplies two source operands per cycle and accepts one result per cycle.

Top module: `rf_2r1w`

## Requirements
- R1: The file holds 32 words of 32 bits, selected by 5-bit addresses. At power-up every word and both read outputs are zero.
- R2: A read address sampled at a rising edge produces its word on the matching read output right after that edge. The output does not change between edges, even if the address changes.
- R3: A write commits at the rising edge when the write enable is 1 and the write address is non-zero. Later reads of that address return the committed data.
- R4: When a write commits and a read port's address equals the write address in the same cycle, that port returns the new write data. Each port applies this rule on its own.
- R5: Reading address 0 always returns zero. A write with address 0 leaves every entry unchanged.
- R6: A write attempt with address 0 is not forwarded. A port reading address 0 in that cycle returns zero.
- R7: When the write enable is 0, both ports return stored contents, even if a read address equals the write address. With a constant address and no commit to it, a port's output stays unchanged.
- R8: When both read ports present the same address in the same cycle, they return identical data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rd_addr_a | input | 5 | Address of read port A |
| rd_addr_b | input | 5 | Address of read port B |
| wr_addr | input | 5 | Address of the write port |
| wr_data | input | 32 | Word to be written |
| wr_en | input | 1 | Write request, high for one write per cycle |
| rd_data_a | output | 32 | Registered read data of port A |
| rd_data_b | output | 32 | Registered read data of port B |

## Verification
Every read result is due exactly one rising edge after its address is driven, and a committed write becomes visible to an ordinary read from the next cycle on. The bench drives inputs two nanoseconds after an edge and compares the outputs two nanoseconds after the following edge. This lets each expected value be tied to one known cycle. One directed step also samples an output midway through a cycle after changing the address, to confirm that nothing moves before the edge. The forwarding cases put the write and the matching read in the same cycle and expect the new word on the very next edge.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // default geometry of the register file
    localparam int RF_DEPTH_DEF = 32;
    localparam int RF_WIDTH_DEF = 32;
    localparam int RF_NUM_RD    = 2;

    // where a read port takes its next output word from
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,
        SRC_FWD   = 2'd1,
        SRC_ZERO  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/rf_wr_gate.sv
module rf_wr_gate #(
    parameter int AW = 5
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    output logic          commit
);

    // a write only takes effect for a non-zero target
    always_comb begin
        commit = wr_en && (wr_addr != '0);
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DEPTH  = 32,
    parameter int DW     = 32,
    parameter int NUM_RD = 2,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          commit,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr [NUM_RD],
    output logic [DW-1:0] rd_raw  [NUM_RD]
);

    logic [DW-1:0] word_q [DEPTH];

    // entry 0 holds no state; every other entry is one register
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        if (e == 0) begin : g_zero
            assign word_q[e] = '0;
        end else begin : g_reg
            typedef struct packed {
                logic [DW-1:0] word;
            } ent_state_t;

            ent_state_t ent_d;
            ent_state_t ent_q = '0;

            always_comb begin
                ent_d = ent_q;
                if (commit && (wr_addr == AW'(e))) begin
                    ent_d.word = wr_data;
                end
            end

            always_ff @(posedge clk) begin
                ent_q <= ent_d;
            end

            assign word_q[e] = ent_q.word;
        end
    end

    // unregistered array look-up, one per read port
    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            rd_raw[p] = word_q[rd_addr[p]];
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_raw,
    input  logic          commit,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    typedef struct packed {
        logic [DW-1:0] data;
    } port_state_t;

    port_state_t port_d;
    port_state_t port_q = '0;
    rd_src_e     src;

    // choose the source of the next output word
    always_comb begin
        if (rd_addr == '0) begin
            src = SRC_ZERO;
        end else if (commit && (rd_addr == wr_addr)) begin
            src = SRC_FWD;
        end else begin
            src = SRC_ARRAY;
        end
    end

    always_comb begin
        port_d = port_q;
        unique case (src)
            SRC_ZERO:  port_d.data = '0;
            SRC_FWD:   port_d.data = wr_data;
            SRC_ARRAY: port_d.data = rd_raw;
            default:   port_d.data = rd_raw;
        endcase
    end

    always_ff @(posedge clk) begin
        port_q <= port_d;
    end

    assign rd_data = port_q.data;

endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w
    import rf_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH_DEF,
    parameter int DW    = RF_WIDTH_DEF,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b
);

    localparam int NR = RF_NUM_RD;

    logic          commit;
    logic [AW-1:0] rd_addr [NR];
    logic [DW-1:0] rd_raw  [NR];
    logic [DW-1:0] rd_data [NR];

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    rf_wr_gate #(.AW(AW)) u_gate (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .commit  (commit)
    );

    rf_storage #(.DEPTH(DEPTH), .DW(DW), .NUM_RD(NR)) u_store (
        .clk     (clk),
        .commit  (commit),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_raw  (rd_raw)
    );

    for (genvar p = 0; p < NR; p++) begin : g_port
        rf_read_port #(.AW(AW), .DW(DW)) u_port (
            .clk     (clk),
            .rd_addr (rd_addr[p]),
            .rd_raw  (rd_raw[p]),
            .commit  (commit),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_data (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

endmodule

// File: rtl/rf_2r1w_chk.sv
module rf_2r1w_chk #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input logic          clk,
    input logic [AW-1:0] rd_addr_a,
    input logic [AW-1:0] rd_addr_b,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_en,
    input logic [DW-1:0] rd_data_a,
    input logic [DW-1:0] rd_data_b
);

    // checks start once two edges have passed, so $past has history
    logic [1:0] live_q = '0;
    logic       live;
    logic       wr_ok;

    always_ff @(posedge clk) begin
        if (live_q != 2'd3) live_q <= live_q + 2'd1;
    end

    assign live  = (live_q >= 2'd2);
    assign wr_ok = wr_en && (wr_addr != '0);

    // R4
    fwd_a_chk: assert property (@(posedge clk) disable iff (!live)
        (wr_ok && rd_addr_a == wr_addr) |=> (rd_data_a == $past(wr_data)));

    // R4
    fwd_b_chk: assert property (@(posedge clk) disable iff (!live)
        (wr_ok && rd_addr_b == wr_addr) |=> (rd_data_b == $past(wr_data)));

    // R5
    zero_a_chk: assert property (@(posedge clk) disable iff (!live)
        (rd_addr_a == '0) |=> (rd_data_a == '0));

    // R5
    zero_b_chk: assert property (@(posedge clk) disable iff (!live)
        (rd_addr_b == '0) |=> (rd_data_b == '0));

    // R8
    same_addr_chk: assert property (@(posedge clk) disable iff (!live)
        (rd_addr_a == rd_addr_b) |=> (rd_data_a == rd_data_b));

    // R7
    hold_a_chk: assert property (@(posedge clk) disable iff (!live)
        (rd_addr_a == $past(rd_addr_a)
         && !($past(wr_ok) && $past(wr_addr) == rd_addr_a)
         && !(wr_ok && wr_addr == rd_addr_a)) |=> $stable(rd_data_a));

    // R7
    hold_b_chk: assert property (@(posedge clk) disable iff (!live)
        (rd_addr_b == $past(rd_addr_b)
         && !($past(wr_ok) && $past(wr_addr) == rd_addr_b)
         && !(wr_ok && wr_addr == rd_addr_b)) |=> $stable(rd_data_b));

endmodule

bind rf_2r1w rf_2r1w_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rd_addr_a (rd_addr_a),
    .rd_addr_b (rd_addr_b),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/rf_2r1w_bench.sv
module rf_2r1w_bench;

    logic        clk = 1'b0;
    logic [4:0]  rd_addr_a = '0;
    logic [4:0]  rd_addr_b = '0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rf_2r1w u_rf_2r1w (
        .clk       (clk),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    typedef struct packed {
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    // stimulus and expected outputs after the edge that ends the cycle
    localparam vec_t VEC [12] = '{
        '{1'b0, 5'd0,  32'h0000_0000, 5'd0,  5'd0,  32'h0000_0000, 32'h0000_0000},
        '{1'b1, 5'd5,  32'hA5A5_0001, 5'd5,  5'd6,  32'hA5A5_0001, 32'h0000_0000},
        '{1'b1, 5'd6,  32'hFFFF_FFDD, 5'd5,  5'd6,  32'hA5A5_0001, 32'hFFFF_FFDD},
        '{1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  5'd0,  32'h0000_0000, 32'h0000_0000},
        '{1'b0, 5'd5,  32'h1234_5678, 5'd5,  5'd5,  32'hA5A5_0001, 32'hA5A5_0001},
        '{1'b1, 5'd5,  32'h0000_0042, 5'd5,  5'd6,  32'h0000_0042, 32'hFFFF_FFDD},
        '{1'b1, 5'd31, 32'h8000_0000, 5'd6,  5'd31, 32'hFFFF_FFDD, 32'h8000_0000},
        '{1'b0, 5'd0,  32'h0000_0000, 5'd31, 5'd0,  32'h8000_0000, 32'h0000_0000},
        '{1'b1, 5'd1,  32'h0000_0001, 5'd0,  5'd1,  32'h0000_0000, 32'h0000_0001},
        '{1'b1, 5'd1,  32'h0000_0002, 5'd1,  5'd1,  32'h0000_0002, 32'h0000_0002},
        '{1'b0, 5'd0,  32'h0000_0000, 5'd1,  5'd5,  32'h0000_0002, 32'h0000_0042},
        '{1'b1, 5'd0,  32'hFFFF_FFFF, 5'd1,  5'd0,  32'h0000_0002, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle, then sample two ns after the edge that ends it
    task automatic cyc(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
        wr_en     = we;
        wr_addr   = wa;
        wr_data   = wd;
        rd_addr_a = ra;
        rd_addr_b = rb;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'h0101_0101 * i) ^ 32'hF000_0000;
    endfunction

    initial begin
        #(10 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs zero before the first edge
        #1;
        check("R1 initial port A", rd_data_a, 32'h0);
        check("R1 initial port B", rd_data_b, 32'h0);

        // R1: every entry reads zero at power-up
        for (int i = 0; i < 32; i++) begin
            cyc(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
            check("R1 power-up port A", rd_data_a, 32'h0);
            check("R1 power-up port B", rd_data_b, 32'h0);
        end

        // R3 R4 R5 R6 R7 R8: vector table
        for (int v = 0; v < 12; v++) begin
            cyc(VEC[v].we, VEC[v].wa, VEC[v].wd, VEC[v].ra, VEC[v].rb);
            check($sformatf("R3/R4/R6/R7/R8 vector %0d port A", v), rd_data_a, VEC[v].ea);
            check($sformatf("R3/R4/R6/R7/R8 vector %0d port B", v), rd_data_b, VEC[v].eb);
        end

        // R2: output only moves at the edge
        cyc(1'b1, 5'd9, 32'hCAFE_0009, 5'd9, 5'd0);
        check("R2 forwarded write to entry 9", rd_data_a, 32'hCAFE_0009);
        wr_en = 1'b0;
        rd_addr_a = 5'd7;
        #3;
        check("R2 output unchanged before edge", rd_data_a, 32'hCAFE_0009);
        @(posedge clk);
        #2;
        check("R2 new address after edge", rd_data_a, 32'h0);

        // R7: write enable low with matching addresses returns stored word
        cyc(1'b0, 5'd9, 32'h5555_5555, 5'd9, 5'd9);
        check("R7 no forward port A", rd_data_a, 32'hCAFE_0009);
        check("R7 no forward port B", rd_data_b, 32'hCAFE_0009);

        // R3 R5: fill every entry, readers parked on entry 0
        for (int i = 1; i < 32; i++) begin
            cyc(1'b1, 5'(i), pat(i), 5'd0, 5'd0);
            check("R5 zero read during fill", rd_data_a, 32'h0);
        end

        // R6: write attempt to entry 0 with both ports reading it
        cyc(1'b1, 5'd0, 32'hFFFF_0000, 5'd0, 5'd0);
        check("R6 no forward on port A", rd_data_a, 32'h0);
        check("R6 no forward on port B", rd_data_b, 32'h0);

        // R3 R5: read back the whole file
        for (int i = 0; i < 32; i++) begin
            cyc(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
            check("R3 readback port A", rd_data_a, (i == 0) ? 32'h0 : pat(i));
            check("R3 readback port B", rd_data_b, (i == 31) ? 32'h0 : pat(31 - i));
        end

        // R4: each port forwards on its own
        cyc(1'b1, 5'd12, 32'h0BAD_F00D, 5'd12, 5'd13);
        check("R4 port A forwards", rd_data_a, 32'h0BAD_F00D);
        check("R4 port B keeps stored", rd_data_b, pat(13));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule